// File: doc/BRIEF.md
# Packed Integer SIMD ALU

This block is a 64-bit packed integer datapath for a vector execution pipe. Each cycle it takes two operands, an opcode, a lane-size select and a shift count. It forms the result in combinational logic and captures it in a single output register. The result therefore appears on `res_o` one clock after the operands are presented.

The operand is cut into independent lanes of 8, 16, 32 or 64 bits. Carries, borrows and shifted bits stay inside their own lane. Compares produce per-lane masks and no status bits. The bitwise operations ignore the lane size. Combinations that the operation set does not define give a zero result:
- byte-lane shifts,
- quad-lane add, subtract or compare,
- unassigned opcodes.

Top module: `simd_alu`

## Requirements
- R1: While `rst_ni` is low, `res_o` is zero, and it clears as soon as reset is asserted. Outside reset, `res_o` holds the result of the inputs sampled at the previous rising clock edge.
- R2: Opcode 0 (add) adds `a_i` and `b_i` per lane, modulo the lane width, with no carry into the next lane. The lane size comes from `size_i`: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits.
- R3: Opcode 1 (subtract) gives `a_i - b_i` per lane for `size_i` 0, 1 or 2, wrapping modulo the lane width, with no borrow from the next lane.
- R4: Opcode 2 (compare equal) sets each lane to all ones when the lanes of `a_i` and `b_i` are equal and to all zeros otherwise, for `size_i` 0, 1 or 2.
- R5: Opcode 3 (compare greater) sets each lane to all ones when the lane of `a_i` is greater than that of `b_i` as a signed two's-complement value, and to all zeros otherwise, for `size_i` 0, 1 or 2.
- R6: Opcodes 4, 5, 6 and 7 give `a_i & b_i`, `~a_i & b_i`, `a_i | b_i` and `a_i ^ b_i` over all 64 bits, whatever the value of `size_i`.
- R7: Opcode 8 shifts each lane of `a_i` left and opcode 9 shifts it right, by `cnt_i`, filling with zeros. This applies for `size_i` 1, 2 and 3. No bit moves into a neighbouring lane, and `b_i` has no effect.
- R8: Opcode 10 shifts each lane of `a_i` right by `cnt_i`, filling with copies of that lane's sign bit, for `size_i` 1, 2 and 3.
- R9: A shift count at or above the lane width gives a zero lane for opcodes 8 and 9, and a lane filled with its sign bit for opcode 10.
- R10: The result is zero for shifts with `size_i` 0, for opcodes 0 to 3 with `size_i` 3, and for opcodes 11 to 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Lane size select |
| cnt_i | input | CNT_W (8) | Shift count |
| a_i | input | DATA_W (64) | First operand; the value shifted |
| b_i | input | DATA_W (64) | Second operand |
| res_o | output | DATA_W (64) | Registered result |

## Verification
The bench builds the block with DATA_W = 64 and CNT_W = 8. With 8 count bits, shift amounts run up to 255, beyond every lane width, so the saturating cases of R9 can be driven, including a count of 200 on 16-bit lanes. The vectors place carries, borrows and shifted-out bits exactly at lane edges, so that any leakage between lanes changes a neighbouring lane. They also place signed compares at the most-negative and most-positive lane values.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CEQ  = 4'd2,
    OP_CGT  = 4'd3,
    OP_AND  = 4'd4,
    OP_ANDN = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_SLL  = 4'd8,
    OP_SRL  = 4'd9,
    OP_SRA  = 4'd10
  } op_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_Q = 2'd3
  } size_e;

  localparam int unsigned NUM_SIZES = 4;
  localparam int unsigned MIN_LANE_W = 8;
endpackage

// File: rtl/simd_lane_arith.sv
module simd_lane_arith #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [DATA_W-1:0] dif_o,
  output logic [DATA_W-1:0] eq_o,
  output logic [DATA_W-1:0] gt_o
);
  localparam int NUM_LANES = DATA_W / LANE_W;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] la, lb;
    assign la = a_i[l*LANE_W +: LANE_W];
    assign lb = b_i[l*LANE_W +: LANE_W];
    // lane-local adders: no carry path between lanes
    assign sum_o[l*LANE_W +: LANE_W] = la + lb;
    assign dif_o[l*LANE_W +: LANE_W] = la - lb;
    assign eq_o[l*LANE_W +: LANE_W]  = {LANE_W{la == lb}};
    assign gt_o[l*LANE_W +: LANE_W]  = {LANE_W{$signed(la) > $signed(lb)}};
  end
endmodule

// File: rtl/simd_lane_shift.sv
module simd_lane_shift #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] sll_o,
  output logic [DATA_W-1:0] srl_o,
  output logic [DATA_W-1:0] sra_o
);
  localparam int NUM_LANES = DATA_W / LANE_W;

  logic big;
  assign big = int'(cnt_i) >= LANE_W;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] la;
    logic              sgn;
    assign la  = a_i[l*LANE_W +: LANE_W];
    assign sgn = la[LANE_W-1];
    assign sll_o[l*LANE_W +: LANE_W] = big ? '0 : (la << cnt_i);
    assign srl_o[l*LANE_W +: LANE_W] = big ? '0 : (la >> cnt_i);
    assign sra_o[l*LANE_W +: LANE_W] = big ? {LANE_W{sgn}}
                                           : LANE_W'($signed(la) >>> cnt_i);
  end
endmodule

// File: rtl/simd_logic_unit.sv
module simd_logic_unit #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        sel_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    case (sel_i)
      2'd0:    res_o = a_i & b_i;
      2'd1:    res_o = ~a_i & b_i;
      2'd2:    res_o = a_i | b_i;
      default: res_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] sum_w [NUM_SIZES];
  logic [DATA_W-1:0] dif_w [NUM_SIZES];
  logic [DATA_W-1:0] eq_w  [NUM_SIZES];
  logic [DATA_W-1:0] gt_w  [NUM_SIZES];
  logic [DATA_W-1:0] sll_w [NUM_SIZES];
  logic [DATA_W-1:0] srl_w [NUM_SIZES];
  logic [DATA_W-1:0] sra_w [NUM_SIZES];
  logic [DATA_W-1:0] logic_res;
  logic [DATA_W-1:0] res_d;
  op_e               op;
  size_e             sz;

  assign op = op_e'(op_i);
  assign sz = size_e'(size_i);

  for (genvar gi = 0; gi < NUM_SIZES; gi++) begin : g_sz
    localparam int LW = MIN_LANE_W << gi;
    // arithmetic and compares exist for 8/16/32-bit lanes only
    if (gi < NUM_SIZES - 1) begin : g_arith
      simd_lane_arith #(.DATA_W(DATA_W), .LANE_W(LW)) i_arith (
        .a_i  (a_i),
        .b_i  (b_i),
        .sum_o(sum_w[gi]),
        .dif_o(dif_w[gi]),
        .eq_o (eq_w[gi]),
        .gt_o (gt_w[gi])
      );
    end else begin : g_no_arith
      assign sum_w[gi] = '0;
      assign dif_w[gi] = '0;
      assign eq_w[gi]  = '0;
      assign gt_w[gi]  = '0;
    end
    // shifts exist for 16/32/64-bit lanes only
    if (gi > 0) begin : g_shift
      simd_lane_shift #(.DATA_W(DATA_W), .LANE_W(LW), .CNT_W(CNT_W)) i_shift (
        .a_i  (a_i),
        .cnt_i(cnt_i),
        .sll_o(sll_w[gi]),
        .srl_o(srl_w[gi]),
        .sra_o(sra_w[gi])
      );
    end else begin : g_no_shift
      assign sll_w[gi] = '0;
      assign srl_w[gi] = '0;
      assign sra_w[gi] = '0;
    end
  end

  simd_logic_unit #(.DATA_W(DATA_W)) i_logic (
    .a_i  (a_i),
    .b_i  (b_i),
    .sel_i(op_i[1:0]),
    .res_o(logic_res)
  );

  always_comb begin
    res_d = '0;
    case (op)
      OP_ADD:  if (sz != SZ_Q) res_d = sum_w[sz];
      OP_SUB:  if (sz != SZ_Q) res_d = dif_w[sz];
      OP_CEQ:  if (sz != SZ_Q) res_d = eq_w[sz];
      OP_CGT:  if (sz != SZ_Q) res_d = gt_w[sz];
      OP_AND, OP_ANDN, OP_OR, OP_XOR: res_d = logic_res;
      OP_SLL:  if (sz != SZ_B) res_d = sll_w[sz];
      OP_SRL:  if (sz != SZ_B) res_d = srl_w[sz];
      OP_SRA:  if (sz != SZ_B) res_d = sra_w[sz];
      default: res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_o <= '0;
    else         res_o <= res_d;
  end
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        op_i,
  input logic [1:0]        size_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [DATA_W-1:0] res_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r1: assert (res_o == '0);
    end
  end

  // R4 / R5: byte-lane compares yield a whole-lane mask
  for (genvar l = 0; l < DATA_W / 8; l++) begin : g_mask
    p_cmp_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((op_i == OP_CEQ || op_i == OP_CGT) && size_i == SZ_B)
      |=> (res_o[l*8 +: 8] == 8'h00 || res_o[l*8 +: 8] == 8'hFF));
  end

  p_eq_self_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CEQ && size_i != SZ_Q && a_i == b_i) |=> (res_o == '1));

  p_sub_self_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SUB && size_i != SZ_Q && a_i == b_i) |=> (res_o == '0));

  p_add_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ADD && size_i != SZ_Q && b_i == '0) |=> (res_o == $past(a_i)));

  p_xor_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_XOR) |=> (res_o == $past(a_i ^ b_i)));

  p_shift_big_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SRL && size_i == SZ_Q && int'(cnt_i) >= 64) |=> (res_o == '0));

  p_undef_op_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > 4'd10) |=> (res_o == '0));
endmodule

bind simd_alu simd_alu_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_simd_alu_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .op_i  (op_i),
  .size_i(size_i),
  .cnt_i (cnt_i),
  .a_i   (a_i),
  .b_i   (b_i),
  .res_o (res_o)
);

// File: tb/test_simd_alu.sv
module test_simd_alu;
  typedef struct packed {
    logic [3:0]  op;
    logic [1:0]  sz;
    logic [7:0]  cnt;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    // R2 add, lane-edge carries
    '{4'd0, 2'd0, 8'd0, 64'h80FF_7F01_0000_00FF, 64'h8001_0101_0000_0001, 64'h0000_8002_0000_0000, 4'd2},
    '{4'd0, 2'd1, 8'd0, 64'hFFFF_0001_7FFF_1234, 64'h0001_0001_0001_1111, 64'h0000_0002_8000_2345, 4'd2},
    '{4'd0, 2'd2, 8'd0, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, 64'h0000_0000_0000_0000, 4'd2},
    // R3 subtract, lane-edge borrows
    '{4'd1, 2'd0, 8'd0, 64'h0010_80FF_0000_0005, 64'h0101_0101_0000_0005, 64'hFF0F_7FFE_0000_0000, 4'd3},
    '{4'd1, 2'd2, 8'd0, 64'h0000_0000_0000_0010, 64'h0000_0001_0000_0001, 64'hFFFF_FFFF_0000_000F, 4'd3},
    // R4 compare equal
    '{4'd2, 2'd0, 8'd0, 64'h1122_3344_5566_7788, 64'h1122_0044_5500_7788, 64'hFFFF_00FF_FF00_FFFF, 4'd4},
    '{4'd2, 2'd1, 8'd0, 64'hAAAA_BBBB_CCCC_DDDD, 64'hAAAA_BBBC_CCCC_0000, 64'hFFFF_0000_FFFF_0000, 4'd4},
    '{4'd2, 2'd2, 8'd0, 64'h1234_5678_0000_0000, 64'h1234_5678_0000_0001, 64'hFFFF_FFFF_0000_0000, 4'd4},
    // R5 signed greater
    '{4'd3, 2'd0, 8'd0, 64'h0180_7F00_FF05_0000, 64'h007F_8000_FE05_FF01, 64'hFF00_FF00_FF00_FF00, 4'd5},
    '{4'd3, 2'd1, 8'd0, 64'h0001_FFFF_8000_7FFF, 64'h0000_0000_7FFF_8000, 64'hFFFF_0000_0000_FFFF, 4'd5},
    '{4'd3, 2'd2, 8'd0, 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 4'd5},
    // R6 bitwise, size ignored
    '{4'd4, 2'd0, 8'd0, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_00FF_1234, 64'h00F0_1234_00FF_0000, 4'd6},
    '{4'd5, 2'd3, 8'd0, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_00FF_1234, 64'h0F00_EDCB_0000_1234, 4'd6},
    '{4'd6, 2'd1, 8'd0, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_00FF_1234, 64'hFFF0_FFFF_FFFF_1234, 4'd6},
    '{4'd7, 2'd2, 8'd0, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_00FF_1234, 64'hFF00_EDCB_FF00_1234, 4'd6},
    // R7 logical shifts; b is all ones to show it is ignored
    '{4'd8, 2'd1, 8'd4, 64'h8001_1234_F00F_0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0010_2340_00F0_0010, 4'd7},
    '{4'd9, 2'd2, 8'd8, 64'h8000_00FF_1234_5678, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0080_0000_0012_3456, 4'd7},
    '{4'd9, 2'd2, 8'd4, 64'h0000_0010_0000_0100, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0010, 4'd7},
    '{4'd8, 2'd3, 8'd63, 64'h0000_0000_0000_0001, 64'h0, 64'h8000_0000_0000_0000, 4'd7},
    '{4'd9, 2'd1, 8'd0, 64'h8001_1234_F00F_0001, 64'h0, 64'h8001_1234_F00F_0001, 4'd7},
    // R8 arithmetic right shift
    '{4'd10, 2'd1, 8'd4, 64'h8000_7FF0_F00F_0100, 64'h0, 64'hF800_07FF_FF00_0010, 4'd8},
    '{4'd10, 2'd2, 8'd31, 64'h8000_0000_7FFF_FFFF, 64'h0, 64'hFFFF_FFFF_0000_0000, 4'd8},
    '{4'd10, 2'd3, 8'd4, 64'h8000_0000_0000_0000, 64'h0, 64'hF800_0000_0000_0000, 4'd8},
    // R9 count at or above lane width
    '{4'd9, 2'd3, 8'd64, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 4'd9},
    '{4'd9, 2'd1, 8'd16, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 4'd9},
    '{4'd8, 2'd2, 8'd32, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 4'd9},
    '{4'd10, 2'd1, 8'd200, 64'h8000_7FFF_FFFF_0001, 64'h0, 64'hFFFF_0000_FFFF_0000, 4'd9},
    '{4'd10, 2'd3, 8'd64, 64'h8000_0000_0000_0000, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 4'd9},
    // R10 undefined combinations
    '{4'd8, 2'd0, 8'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 4'd10},
    '{4'd0, 2'd3, 8'd0, 64'h0000_0000_0000_0001, 64'h1, 64'h0, 4'd10},
    '{4'd2, 2'd3, 8'd0, 64'h1234, 64'h1234, 64'h0, 4'd10},
    '{4'd15, 2'd0, 8'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 4'd10},
    '{4'd11, 2'd1, 8'd3, 64'h5555_5555_5555_5555, 64'h1, 64'h0, 4'd10}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  size = '0;
  logic [7:0]  cnt = '0;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic [63:0] res;
  int          checks = 0;
  int          fails = 0;

  always #10 clk = ~clk;

  simd_alu #(.DATA_W(64), .CNT_W(8)) i_simd_alu (
    .clk_i (clk),
    .rst_ni(rst_n),
    .op_i  (op),
    .size_i(size),
    .cnt_i (cnt),
    .a_i   (a),
    .b_i   (b),
    .res_o (res)
  );

  task automatic check(input logic [63:0] exp, input int req);
    checks++;
    if (res !== exp) begin
      fails++;
      $display("FAIL R%0d: got %h expected %h", req, res, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R1: held in reset with live operands
    op = 4'd7; a = 64'hDEAD_BEEF_0123_4567; b = 64'h1;
    repeat (3) @(negedge clk);
    check(64'h0, 1);
    rst_n = 1'b1;
    // R1: first result one cycle after release
    @(negedge clk);
    check(64'hDEAD_BEEF_0123_4566, 1);

    for (int i = 0; i < NV; i++) begin
      op = VECS[i].op; size = VECS[i].sz; cnt = VECS[i].cnt;
      a = VECS[i].a; b = VECS[i].b;
      @(negedge clk);
      check(VECS[i].exp, int'(VECS[i].req));
    end

    // R1: async clear mid-run
    op = 4'd6; size = 2'd0; a = 64'hFFFF_0000_FFFF_0000; b = 64'h0;
    @(negedge clk);
    check(64'hFFFF_0000_FFFF_0000, 6);
    #3 rst_n = 1'b0;
    #1 check(64'h0, 1);
    @(negedge clk);
    rst_n = 1'b1;
    // R2: back-to-back vectors, each visible one cycle later
    op = 4'd0; size = 2'd1; a = 64'h0001_0002_0003_FFFF; b = 64'h0001_0001_0001_0001;
    @(negedge clk);
    check(64'h0002_0003_0004_0000, 2);
    op = 4'd1; size = 2'd1;
    @(negedge clk);
    check(64'h0000_0001_0002_FFFE, 3);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule